// File: doc/BRIEF.md
# SPI Serial EEPROM Command Engine

This block behaves as a small byte-wide serial EEPROM on an SPI bus. It holds a 512-byte array and answers commands on the serial pins in the two clock polarities where data enters on the rising clock edge: idle-low (mode 0) and idle-high (mode 3). A fast system clock oversamples the chip select, serial clock and serial data pins. The rising and falling edges of the serial clock are detected in the system clock domain. Each transaction begins with an 8-bit instruction. Memory instructions follow it with an address byte and a data stream. Bit 3 of the instruction is the ninth address bit.

Writes go through a 16-byte page buffer. The buffer is copied into the array only if chip select rises exactly on a byte boundary, and only while the write enable latch is set. After that, a programmable count of system clocks stands in for the self-timed write cycle, and the busy flag is set for that time. A small protection unit decides, from two block-protect bits in the status register, whether the addressed page may be written. Status reads work at any time. Array commands issued during a write cycle are rejected.

Top module: `spi_eeprom_engine`

## Requirements
- R1: Input bits are taken on the rising edge of the serial clock, MSB first. The output bit changes only after a falling edge. Both idle-low (mode 0) and idle-high (mode 3) serial clocks work.
- R2: Instruction codes are 0x06 set-latch, 0x04 clear-latch, 0x05 status read, 0x01 status write, 0000_A011 array read and 0000_A010 array write. For the two array instructions, bit 3 (A) becomes address bit 8, above the 8-bit address byte that follows.
- R3: After an instruction code outside this set, miso_oe stays low and all further input is ignored until chip select goes high.
- R4: 0x06 sets the write enable latch and 0x04 clears it. After either of these, or after a status read, further input has no effect until chip select goes high.
- R5: A status read returns the byte {1111, P1, P0, WEL, BUSY}, MSB first, with P1/P0 in bits 3:2, the latch in bit 1 and the busy flag in bit 0. The byte is sent again for as long as clocks continue.
- R6: An array read streams bytes from the given address. The address increments after each byte and wraps from 0x1FF to 0x000.
- R7: An array write takes 1 to 16 data bytes. The low 4 address bits wrap within the 16-byte page, so later bytes overwrite earlier bytes at the same page offset.
- R8: A write takes effect only if chip select rises after a whole number of data bytes (at least one) while the latch is set. A commit clears the latch. A rise at any other point cancels the write and leaves both the array and the latch unchanged.
- R9: A committed write sets BUSY for WR_CYCLES system clocks. An array read, array write or status write issued while BUSY is set is ignored: nothing is driven and nothing changes.
- R10: A status write commits only if exactly 8 data bits were received before chip select rises. The new P1/P0 value (data bits 3:2) is applied when the write cycle ends. Until then, status reads show the old value.
- R11: The protected area is set by P1/P0: 00 none, 01 0x180-0x1FF, 10 0x100-0x1FF, 11 the whole array. A byte-aligned write to a protected page clears the latch, leaves the array unchanged and does not start a write cycle.
- R12: After reset the array reads 0xFF, P1/P0 and the latch are 0, and miso_oe is low. miso_oe is low whenever chip select is high or no output phase is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock pin |
| cs_n | input | 1 | Active-low chip select pin |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Output enable for miso; low means tri-stated |

## Verification
The assertions assume the serial pins are slow compared with the system clock. Each serial clock phase and each chip select change must last several system clocks, so that every edge is seen once through the synchronizer. They also assume chip select never changes in the same sampled cycle as a serial clock edge. The stimulus holds each serial clock phase for eight system clocks. It changes chip select half a serial period away from any clock edge, and it drives every pin on the falling system clock edge.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam int ADDR_W = 9;
  localparam int PAGE_W = 4;

  localparam logic [7:0] OP_SETL = 8'h06;
  localparam logic [7:0] OP_CLRL = 8'h04;
  localparam logic [7:0] OP_STRD = 8'h05;
  localparam logic [7:0] OP_STWR = 8'h01;
  localparam logic [2:0] OP_RDLO = 3'b011;
  localparam logic [2:0] OP_WRLO = 3'b010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_RDAT, ST_WDAT, ST_SOUT, ST_SIN, ST_WAIT
  } ee_state_t;
endpackage

// File: rtl/ee_sync.sv
module ee_sync #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {2{RST_VAL[g]}};
      else        pipe <= {pipe[0], din[g]};
    end
    assign q[g] = pipe[1];
  end
endmodule

// File: rtl/ee_protect.sv
module ee_protect (
  input  logic [1:0] bp,
  input  logic [1:0] region,
  output logic       prot
);
  always_comb begin
    unique case (bp)
      2'b00:   prot = 1'b0;
      2'b01:   prot = (region == 2'b11);
      2'b10:   prot = region[1];
      default: prot = 1'b1;
    endcase
  end
endmodule

// File: rtl/spi_eeprom_engine.sv
module spi_eeprom_engine
  import ee_pkg::*;
#(
  parameter int WR_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic miso,
  output logic miso_oe
);
  localparam int CW    = $clog2(WR_CYCLES + 1);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;

  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  logic [2:0] pins_s;
  logic cs_s, sck_s, mosi_s, sck_d, cs_d;
  logic sck_rise, sck_fall, cs_rise;
  ee_sync #(.N(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_ni), .din({cs_n, sck, mosi}), .q(pins_s));
  assign cs_s     = pins_s[2];
  assign sck_s    = pins_s[1];
  assign mosi_s   = pins_s[0];
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign cs_rise  = cs_s & ~cs_d;

  ee_state_t         state, state_n;
  logic [2:0]        bitcnt, bitcnt_n;
  logic [7:0]        shreg, shreg_n, oreg, oreg_n;
  logic              miso_q, miso_n, oe_q, oe_n;
  logic [ADDR_W-1:0] addr, addr_n;
  logic              is_wr, is_wr_n, byte_ok, byte_ok_n;
  logic [PAGE_W-1:0] pg_off, pg_off_n;
  logic [PAGE-1:0]   pmask, pmask_n;
  logic [1:0]        sr_new, sr_new_n, bp, bp_n, bp_pend, bp_pend_n;
  logic              bp_upd, bp_upd_n, wel, wel_n, busy, busy_n;
  logic [CW-1:0]     cnt, cnt_n;
  logic              start_wr, sr_commit, pb_we, prot;
  logic [7:0]        inbyte, status;
  logic [7:0]        mem  [DEPTH];
  logic [7:0]        pbuf [PAGE];

  assign inbyte  = {shreg[6:0], mosi_s};
  assign status  = {4'hF, bp, wel, busy};
  assign miso    = miso_q;
  assign miso_oe = oe_q;

  ee_protect u_prot (.bp(bp), .region(addr[ADDR_W-1:ADDR_W-2]), .prot(prot));

  always_comb begin
    state_n = state;  bitcnt_n = bitcnt;  shreg_n = shreg;  oreg_n = oreg;
    miso_n = miso_q;  oe_n = oe_q;        addr_n = addr;    is_wr_n = is_wr;
    byte_ok_n = byte_ok;  pg_off_n = pg_off;  pmask_n = pmask;  sr_new_n = sr_new;
    bp_n = bp;  bp_pend_n = bp_pend;  bp_upd_n = bp_upd;  wel_n = wel;
    busy_n = busy;  cnt_n = cnt;
    start_wr = 1'b0;  sr_commit = 1'b0;  pb_we = 1'b0;

    if (busy) begin
      if (cnt == '0) begin
        busy_n = 1'b0;
        if (bp_upd) begin
          bp_n = bp_pend;
          bp_upd_n = 1'b0;
        end
      end else begin
        cnt_n = cnt - 1'b1;
      end
    end

    if (cs_s) begin
      state_n = ST_IDLE;
      oe_n = 1'b0;
      if (cs_rise && byte_ok && wel) begin
        if (state == ST_WDAT) begin
          wel_n = 1'b0;
          start_wr = ~prot;
        end else if (state == ST_SIN) begin
          wel_n = 1'b0;
          sr_commit = 1'b1;
        end
      end
    end else begin
      unique case (state)
        ST_IDLE: begin
          state_n = ST_CMD;
          bitcnt_n = '0;
          byte_ok_n = 1'b0;
        end
        ST_CMD: if (sck_rise) begin
          shreg_n = inbyte;
          bitcnt_n = bitcnt + 1'b1;
          if (bitcnt == 3'd7) begin
            state_n = ST_WAIT;
            if (inbyte == OP_SETL) wel_n = 1'b1;
            else if (inbyte == OP_CLRL) wel_n = 1'b0;
            else if (inbyte == OP_STRD) begin
              state_n = ST_SOUT;
              oreg_n = status;
            end else if (inbyte == OP_STWR) begin
              if (!busy) state_n = ST_SIN;
            end else if (inbyte[7:4] == 4'h0 && !busy &&
                         (inbyte[2:0] == OP_RDLO || inbyte[2:0] == OP_WRLO)) begin
              state_n = ST_ADDR;
              is_wr_n = (inbyte[2:0] == OP_WRLO);
              addr_n[ADDR_W-1] = inbyte[3];
            end
          end
        end
        ST_ADDR: if (sck_rise) begin
          shreg_n = inbyte;
          bitcnt_n = bitcnt + 1'b1;
          if (bitcnt == 3'd7) begin
            addr_n = {addr[ADDR_W-1], inbyte};
            if (is_wr) begin
              state_n = ST_WDAT;
              pg_off_n = inbyte[PAGE_W-1:0];
              pmask_n = '0;
            end else begin
              state_n = ST_RDAT;
              oreg_n = mem[{addr[ADDR_W-1], inbyte}];
              addr_n = {addr[ADDR_W-1], inbyte} + 1'b1;
            end
          end
        end
        ST_RDAT, ST_SOUT: if (sck_fall) begin
          miso_n = oreg[7];
          oe_n = 1'b1;
          oreg_n = {oreg[6:0], 1'b0};
          bitcnt_n = bitcnt + 1'b1;
          if (bitcnt == 3'd7) begin
            if (state == ST_RDAT) begin
              oreg_n = mem[addr];
              addr_n = addr + 1'b1;
            end else begin
              oreg_n = status;
            end
          end
        end
        ST_WDAT: if (sck_rise) begin
          shreg_n = inbyte;
          bitcnt_n = bitcnt + 1'b1;
          byte_ok_n = 1'b0;
          if (bitcnt == 3'd7) begin
            pb_we = 1'b1;
            pmask_n[pg_off] = 1'b1;
            pg_off_n = pg_off + 1'b1;
            byte_ok_n = 1'b1;
          end
        end
        ST_SIN: if (sck_rise) begin
          shreg_n = inbyte;
          bitcnt_n = bitcnt + 1'b1;
          if (byte_ok) begin
            state_n = ST_WAIT;
            byte_ok_n = 1'b0;
          end else if (bitcnt == 3'd7) begin
            sr_new_n = inbyte[3:2];
            byte_ok_n = 1'b1;
          end
        end
        default: ;
      endcase
    end

    if (start_wr || sr_commit) begin
      busy_n = 1'b1;
      cnt_n = CW'(WR_CYCLES - 1);
    end
    if (sr_commit) begin
      bp_pend_n = sr_new;
      bp_upd_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE;  bitcnt <= '0;  shreg <= '0;  oreg <= '0;
      miso_q <= 1'b0;  oe_q <= 1'b0;  addr <= '0;  is_wr <= 1'b0;
      byte_ok <= 1'b0;  pg_off <= '0;  pmask <= '0;  sr_new <= '0;
      bp <= '0;  bp_pend <= '0;  bp_upd <= 1'b0;  wel <= 1'b0;
      busy <= 1'b0;  cnt <= '0;  sck_d <= 1'b0;  cs_d <= 1'b1;
    end else begin
      state <= state_n;  bitcnt <= bitcnt_n;  shreg <= shreg_n;  oreg <= oreg_n;
      miso_q <= miso_n;  oe_q <= oe_n;  addr <= addr_n;  is_wr <= is_wr_n;
      byte_ok <= byte_ok_n;  pg_off <= pg_off_n;  pmask <= pmask_n;  sr_new <= sr_new_n;
      bp <= bp_n;  bp_pend <= bp_pend_n;  bp_upd <= bp_upd_n;  wel <= wel_n;
      busy <= busy_n;  cnt <= cnt_n;  sck_d <= sck_s;  cs_d <= cs_s;
    end
  end

  always_ff @(posedge clk) begin
    if (pb_we) pbuf[pg_off] <= inbyte;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (start_wr) begin
      for (int i = 0; i < PAGE; i++)
        if (pmask[i]) mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
    end
  end
endmodule

// File: rtl/ee_checker.sv
module ee_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_s,
  input logic       sck_fall,
  input logic       miso,
  input logic       miso_oe,
  input logic       busy,
  input logic       wel,
  input logic       start_wr,
  input logic [1:0] bp
);
  // R12
  oe_low_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && $past(cs_s)) |-> !miso_oe);

  // R1
  out_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> $past(sck_fall));

  // R9
  no_start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |-> !busy);

  // R8
  latch_clear_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !wel);

  // R10
  bp_apply_at_cycle_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp) |-> ($past(busy) && !busy));
endmodule

bind spi_eeprom_engine ee_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_fall(sck_fall), .miso(miso),
  .miso_oe(miso_oe), .busy(busy), .wel(wel), .start_wr(start_wr), .bp(bp));

// File: tb/spi_eeprom_engine_test.sv
`timescale 1ns/1ps
module spi_eeprom_engine_test;
  localparam int WRC = 2000;
  localparam int H   = 160;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe;
  logic mode3 = 1'b0;
  int errs = 0, checks = 0;
  bit done = 0;

  logic [7:0] mdl [512];
  logic [1:0] mbp = 2'b00;
  logic       mwel = 1'b0;

  always #10 clk = ~clk;

  spi_eeprom_engine #(.WR_CYCLES(WRC)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_prot(input logic [8:0] a);
    case (mbp)
      2'b00: return 0;
      2'b01: return a >= 9'h180;
      2'b10: return a >= 9'h100;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] stat(input logic wip);
    return {4'hF, mbp, mwel, wip};
  endfunction

  task automatic bitx(input logic b, output logic q, output logic o);
    if (!mode3) begin
      mosi = b; #(H); q = miso; o = miso_oe; sck = 1'b1; #(H); sck = 1'b0;
    end else begin
      sck = 1'b0; mosi = b; #(H); q = miso; o = miso_oe; sck = 1'b1; #(H);
    end
  endtask

  task automatic xbyte(input logic [7:0] d, output logic [7:0] q, output int noe);
    logic qb, ob;
    noe = 0;
    for (int i = 7; i >= 0; i--) begin
      bitx(d[i], qb, ob);
      q[i] = qb;
      if (ob) noe++;
    end
  endtask

  task automatic sel();
    sck = mode3; #(H); cs_n = 1'b0; #(H);
  endtask

  task automatic desel();
    #(H); cs_n = 1'b1; #(2*H);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] q; int n;
    sel(); xbyte(op, q, n); desel();
    if (op == 8'h06) mwel = 1'b1;
    if (op == 8'h04) mwel = 1'b0;
  endtask

  task automatic rdsr(output logic [7:0] s, output int noe);
    logic [7:0] q;
    int n;
    sel(); xbyte(8'h05, q, n); xbyte(8'h00, s, noe); desel();
  endtask

  task automatic wr_page(input logic [8:0] a, input logic [7:0] d[$]);
    logic [7:0] q; int n;
    logic [3:0] off;
    sel();
    xbyte({4'h0, a[8], 3'b010}, q, n);
    xbyte(a[7:0], q, n);
    foreach (d[i]) xbyte(d[i], q, n);
    desel();
    if (mwel) begin
      mwel = 1'b0;
      if (!is_prot(a)) begin
        off = a[3:0];
        foreach (d[i]) begin
          mdl[{a[8:4], off}] = d[i];
          off = off + 1'b1;
        end
      end
    end
  endtask

  task automatic rd(input logic [8:0] a, input int cnt, output logic [7:0] q[$], output int noe);
    logic [7:0] b; int n;
    q = {};
    noe = 0;
    sel();
    xbyte({4'h0, a[8], 3'b011}, b, n);
    xbyte(a[7:0], b, n);
    for (int i = 0; i < cnt; i++) begin
      xbyte(8'h00, b, n);
      q.push_back(b);
      noe += n;
    end
    desel();
  endtask

  task automatic wait_wr();
    repeat (WRC + 20) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, s2, b;
    logic [7:0] q[$];
    logic [7:0] d[$];
    logic qb, ob;
    int n;
    for (int i = 0; i < 512; i++) mdl[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12: reset state
    chk("R12 oe after reset", miso_oe, 0);
    rdsr(s, n);
    chk("R12 R5 status after reset", s, stat(0));
    chk("R1 status output enabled bits", n, 8);
    rd(9'h0A0, 1, q, n);
    chk("R12 erased byte", q[0], 8'hFF);
    chk("R6 read output enabled", n, 8);

    // R8: write without latch is ignored
    wr_page(9'h010, '{8'h12});
    wait_wr();
    rd(9'h010, 1, q, n);
    chk("R8 write without latch", q[0], mdl[9'h010]);

    // R4: set latch, trailing byte ignored
    sel(); xbyte(8'h06, b, n); xbyte(8'h04, b, n); desel();
    mwel = 1'b1;
    rdsr(s, n);
    chk("R4 latch set, extra byte ignored", s, stat(0));
    cmd1(8'h04);
    rdsr(s, n);
    chk("R4 latch cleared", s, stat(0));

    // R2 R9: byte write with A8, busy behaviour
    cmd1(8'h06);
    wr_page(9'h105, '{8'h5A});
    rdsr(s, n);
    chk("R9 busy shown, latch cleared", s, stat(1));
    rd(9'h105, 1, q, n);
    chk("R9 read during busy drives nothing", n, 0);
    wait_wr();
    rd(9'h105, 1, q, n);
    chk("R2 upper half byte", q[0], 8'h5A);
    rd(9'h005, 1, q, n);
    chk("R2 lower half untouched", q[0], 8'hFF);

    // R7: page wrap with overwrite
    cmd1(8'h06);
    d = {};
    for (int i = 0; i < 18; i++) d.push_back(8'h30 + 8'(i));
    wr_page(9'h02E, d);
    wait_wr();
    rd(9'h020, 16, q, n);
    for (int i = 0; i < 16; i++) chk("R7 page wrap", q[i], mdl[9'h020 + i]);

    // R8: misaligned rise cancels
    cmd1(8'h06);
    sel();
    xbyte(8'h02, b, n); xbyte(8'h40, b, n); xbyte(8'h77, b, n);
    for (int i = 0; i < 3; i++) bitx(1'b1, qb, ob);
    desel();
    wait_wr();
    rdsr(s, n);
    chk("R8 cancelled keeps latch", s, stat(0));
    rd(9'h040, 1, q, n);
    chk("R8 cancelled keeps array", q[0], 8'hFF);
    cmd1(8'h04);

    // R6: address wrap on read
    cmd1(8'h06); wr_page(9'h1FF, '{8'hA5}); wait_wr();
    cmd1(8'h06); wr_page(9'h000, '{8'h3C}); wait_wr();
    rd(9'h1FE, 3, q, n);
    chk("R6 byte at 1FE", q[0], mdl[9'h1FE]);
    chk("R6 byte at 1FF", q[1], 8'hA5);
    chk("R6 wrap to 000", q[2], 8'h3C);

    // R5: status repeats
    sel(); xbyte(8'h05, b, n); xbyte(8'h00, s, n); xbyte(8'h00, s2, n); desel();
    chk("R5 status repeats", s2, s);

    // R3: unknown opcode
    sel(); xbyte(8'hFF, b, n); xbyte(8'h06, b, n);
    chk("R3 unknown opcode drives nothing", n, 0);
    desel();
    rdsr(s, n);
    chk("R3 following input ignored", s, stat(0));

    // R10: status write with extra bit cancelled
    cmd1(8'h06);
    sel(); xbyte(8'h01, b, n); xbyte(8'h04, b, n); bitx(1'b0, qb, ob); desel();
    wait_wr();
    rdsr(s, n);
    chk("R10 extra bit cancels status write", s, stat(0));

    // R10: status write commits, old value visible while busy
    sel(); xbyte(8'h01, b, n); xbyte(8'h04, b, n); desel();
    mwel = 1'b0;
    rdsr(s, n);
    chk("R10 old protect bits while busy", s, stat(1));
    wait_wr();
    mbp = 2'b01;
    rdsr(s, n);
    chk("R10 new protect bits", s, stat(0));

    // R11: upper quarter protected
    cmd1(8'h06);
    wr_page(9'h1F0, '{8'h11});
    rdsr(s, n);
    chk("R11 protected write clears latch, no cycle", s, stat(0));
    rd(9'h1F0, 1, q, n);
    chk("R11 protected byte unchanged", q[0], 8'hFF);
    cmd1(8'h06); wr_page(9'h100, '{8'h22}); wait_wr();
    rd(9'h100, 1, q, n);
    chk("R11 outside quarter written", q[0], 8'h22);

    // R11: upper half protected
    cmd1(8'h06);
    sel(); xbyte(8'h01, b, n); xbyte(8'h08, b, n); desel();
    mwel = 1'b0; wait_wr(); mbp = 2'b10;
    cmd1(8'h06); wr_page(9'h100, '{8'h99}); wait_wr();
    rd(9'h100, 1, q, n);
    chk("R11 half protected unchanged", q[0], 8'h22);
    cmd1(8'h06); wr_page(9'h0F0, '{8'h66}); wait_wr();
    rd(9'h0F0, 1, q, n);
    chk("R11 lower half written", q[0], 8'h66);

    // R1: idle-high serial clock
    mode3 = 1'b1;
    rd(9'h105, 2, q, n);
    chk("R1 mode 3 read", q[0], 8'h5A);
    chk("R1 mode 3 next byte", q[1], mdl[9'h106]);
    rdsr(s, n);
    chk("R1 mode 3 status", s, stat(0));
    mode3 = 1'b0;
    #(H);
    chk("R12 oe low when deselected", miso_oe, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule